// File: doc/BRIEF.md
# Byte-Wide Memory Configuration Loader

The loader is the master side of a configuration fetch from byte-wide memory. After a start request it drives an incrementing byte address, pulses a read clock once per byte and takes the byte from the data bus. It then shifts that byte out one bit at a time on a serial data line, with a serial clock beside it. Further devices in a daisy chain can be configured from this serial stream.

By default the byte goes out least significant bit first. A mirror select sends it most significant bit first instead, for memory images stored with the opposite bit order. The number of bytes to load is set by a length input, which is captured at start. When that many bytes have been sent, the loader raises done and drops busy. If the address runs past the top of the address space before the length is reached, the address returns to zero and a sticky error flag is set.

All outputs are registers timed by the system clock `clk`. One byte takes one fetch cycle and then two cycles per bit, the serial clock being low and then high. Parameter `ADDR_W` sets the address width (18 by default), `DATA_W` sets the byte width and `LEN_W` sets the length width.

Top module: `cfg_byte_loader`

## Requirements
- R1: Each run starts at address 0. The address increases by one for each byte, and every read-clock pulse presents the next address in that sequence.
- R2: There is exactly one read-clock pulse per byte, one cycle high. It never coincides with a serial clock high, and the next pulse comes only after the 8th bit of the previous byte has been shifted.
- R3: With mirror = 0, each byte is sent as data bit 0 first, then bits 1 through 7.
- R4: With mirror = 1, each byte is sent as data bit 7 first, then bits 6 down to 0.
- R5: Each byte produces exactly 8 serial-clock pulses, each one cycle high. The serial data changes only while the serial clock is low, so it is stable at every rising edge.
- R6: After the length number of bytes, done = 1 and busy = 0. For a length N > 0, done appears 17·N cycles after the cycle in which start was sampled.
- R7: A length of 0 sets done in the cycle after start and issues no read-clock or serial-clock pulse.
- R8: A start pulse that arrives while busy is high has no effect. The address sequence and the bit stream carry on unchanged.
- R9: If the address must step past its all-ones value before the length is reached, it returns to 0 and wrap_err is set to 1. A run that ends exactly on the all-ones address leaves wrap_err = 0.
- R10: During reset, all outputs are 0.
- R11: A new start clears done and wrap_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start request, sampled while idle |
| cfg_len | input | LEN_W | Number of bytes to load |
| mirror | input | 1 | 1 = send each byte MSB first |
| mem_data | input | DATA_W | Byte from configuration memory |
| mem_addr | output | ADDR_W | Byte address to memory |
| rclk | output | 1 | Read clock, one pulse per byte |
| sdata | output | 1 | Serial configuration data |
| sclk | output | 1 | Serial configuration clock |
| busy | output | 1 | Load in progress |
| done | output | 1 | Length reached |
| wrap_err | output | 1 | Address wrapped before the length was reached |

## Verification
A read-clock pulse is visible one cycle after start is sampled, and again in the cycle after each byte's 8th serial-clock high. The first bit is on sdata in the cycle after the read pulse, and each later bit follows two cycles after the one before it. Done is due 17·N cycles after the start edge, or one cycle after it for a zero length. The bench samples only at falling clock edges. A monitor detects the rising edges of rclk and sclk there and pops the expected address or bit from the queues the driver filled. The driver counts falling edges from start to done and compares that count with the 17·N figure.

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              mirror,
  input  logic [DATA_W-1:0] mem_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rclk,
  output logic              sdata,
  output logic              sclk,
  output logic              busy,
  output logic              done,
  output logic              wrap_err
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  typedef enum logic [1:0] {IDLE, FETCH, SHIFT} state_t;

  state_t            state;
  logic [LEN_W-1:0]  len_q, cnt;
  logic [BIT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg, ordered;
  logic              last_byte;

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      ordered[i] = mirror ? mem_data[DATA_W-1-i] : mem_data[i];
  end

  assign busy      = (state != IDLE);
  assign last_byte = (LEN_W'(cnt + 1'b1) == len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      len_q    <= '0;
      cnt      <= '0;
      bitcnt   <= '0;
      shreg    <= '0;
      mem_addr <= '0;
      rclk     <= 1'b0;
      sdata    <= 1'b0;
      sclk     <= 1'b0;
      done     <= 1'b0;
      wrap_err <= 1'b0;
    end else begin
      case (state)
        IDLE: if (start) begin
          mem_addr <= '0;
          cnt      <= '0;
          len_q    <= cfg_len;
          wrap_err <= 1'b0;
          if (cfg_len == '0) begin
            done <= 1'b1;
          end else begin
            done  <= 1'b0;
            rclk  <= 1'b1;
            state <= FETCH;
          end
        end
        FETCH: begin
          rclk   <= 1'b0;
          sdata  <= ordered[0];
          shreg  <= ordered >> 1;
          bitcnt <= '0;
          sclk   <= 1'b0;
          state  <= SHIFT;
        end
        SHIFT: begin
          if (!sclk) begin
            sclk <= 1'b1;
          end else if (bitcnt == LAST_BIT) begin
            sclk <= 1'b0;
            if (last_byte) begin
              done  <= 1'b1;
              state <= IDLE;
            end else begin
              cnt      <= cnt + 1'b1;
              mem_addr <= mem_addr + 1'b1;
              if (&mem_addr) wrap_err <= 1'b1;
              rclk  <= 1'b1;
              state <= FETCH;
            end
          end else begin
            sclk   <= 1'b0;
            sdata  <= shreg[0];
            shreg  <= shreg >> 1;
            bitcnt <= bitcnt + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R2
  rclk_sclk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rclk |-> !sclk);
  // R2
  rclk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rclk |=> !rclk);
  // R5
  sclk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> !sclk);
  // R5
  sdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdata));
  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mem_addr != $past(mem_addr))
      |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(wrap_err) && wrap_err) |-> mem_addr == '0);
endmodule

// File: tb/cfg_byte_loader_test.sv
module cfg_byte_loader_test;
  localparam int AW = 4;
  localparam int LW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mirror = 1'b0;
  logic [LW-1:0] cfg_len = '0;
  logic [7:0] mem_data;
  logic [AW-1:0] mem_addr;
  logic rclk, sdata, sclk, busy, done, wrap_err;

  int checks = 0, errors = 0;
  logic q_bits[$];
  logic [AW-1:0] q_addr[$];
  logic p_sclk = 1'b0, p_rclk = 1'b0;
  int cycles = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_of(logic [AW-1:0] a);
    return 8'(a * 8'd29 + 8'h5A);
  endfunction

  assign mem_data = mem_of(mem_addr);

  cfg_byte_loader #(.ADDR_W(AW), .DATA_W(8), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
    .mirror(mirror), .mem_data(mem_data), .mem_addr(mem_addr),
    .rclk(rclk), .sdata(sdata), .sclk(sclk), .busy(busy),
    .done(done), .wrap_err(wrap_err));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  // monitor: R1 R2 R3 R4 R5
  always @(negedge clk) begin
    if (rst_n) begin
      if (rclk && !p_rclk) begin
        if (q_addr.size() == 0) check("R2 extra read pulse", 1, 0);
        else check("R1 address", 32'(mem_addr), 32'(q_addr.pop_front()));
      end
      if (sclk && !p_sclk) begin
        if (q_bits.size() == 0) check("R5 extra serial pulse", 1, 0);
        else check(mirror ? "R4 bit" : "R3 bit", 32'(sdata), 32'(q_bits.pop_front()));
      end
    end
    p_rclk = rclk;
    p_sclk = sclk;
  end

  task automatic run(int n, logic m, bit poke, logic exp_err);
    int cnt;
    int exp_cyc;
    @(negedge clk);
    cfg_len = LW'(n);
    mirror = m;
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      logic [7:0] b;
      a = AW'(i);
      b = mem_of(a);
      q_addr.push_back(a);
      for (int k = 0; k < 8; k++) q_bits.push_back(m ? b[7-k] : b[k]);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 5000) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 30) begin
        start = 1'b1;
        check("R8 busy at stray start", 32'(busy), 1);
      end else start = 1'b0;
    end
    start = 1'b0;
    exp_cyc = (n == 0) ? 1 : 17 * n + 1;
    check("R6 done timing", 32'(cnt), 32'(exp_cyc));
    check("R6 done", 32'(done), 1);
    check("R6 busy low", 32'(busy), 0);
    check("R9 wrap flag", 32'(wrap_err), 32'(exp_err));
    check("R1 all addresses seen", 32'(q_addr.size()), 0);
    check("R5 all bits seen", 32'(q_bits.size()), 0);
    repeat (3) @(negedge clk);
    check("R6 done held", 32'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset addr", 32'(mem_addr), 0);
    check("R10 reset rclk/sclk/sdata", {29'd0, rclk, sclk, sdata}, 0);
    check("R10 reset busy/done/err", {29'd0, busy, done, wrap_err}, 0);
    rst_n = 1'b1;
    run(0, 1'b0, 1'b0, 1'b0);   // R7
    run(3, 1'b0, 1'b0, 1'b0);   // R3
    run(4, 1'b1, 1'b0, 1'b0);   // R4
    run(5, 1'b0, 1'b1, 1'b0);   // R8
    run(16, 1'b1, 1'b0, 1'b0);  // R9 exact fit
    run(20, 1'b0, 1'b0, 1'b1);  // R9 wrap
    @(negedge clk);
    cfg_len = LW'(2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11
    check("R11 done cleared", 32'(done), 0);
    check("R11 err cleared", 32'(wrap_err), 0);
    check("R11 restart address", 32'(mem_addr), 0);
    q_addr.push_back('0);
    for (int k = 0; k < 8; k++) q_bits.push_back(mem_of('0) >> k);
    q_addr.push_back(AW'(1));
    for (int k = 0; k < 8; k++) q_bits.push_back(mem_of(AW'(1)) >> k);
    repeat (40) @(negedge clk);
    check("R11 run complete", 32'(done), 1);
    check("R1 queues drained", 32'(q_addr.size() + q_bits.size()), 0);
    finish_run();
  end
endmodule